// File: doc/BRIEF.md
# Object Mailbox Filter for Ray Chunks

This block sits between the traversal stage and the object intersection stage. A group of rays that move through the acceleration tree together is called a chunk. Such a chunk often meets the same object in several leaf cells, because a large object can straddle many cells. Testing that object a second time is wasted work. The filter stops those repeat tests.

Each chunk owns a small fully associative list of object ids that it has tested recently. By default the list has four entries, and the four rays of the chunk share it. A request carries a chunk id and an object id. The filter compares the object id against every entry of that chunk's list in one cycle. If a valid entry matches, the request is dropped and a hit counter advances. If nothing matches, the request is passed on, and the object id is written into the list at the chunk's round-robin slot.

A clear input empties one chunk's list in a single cycle. It is used when that chunk starts a new trace. The filter answers each request exactly one cycle after it arrives.

Top module: `obj_mailbox`

## Requirements
- R1: After reset `rspValid` and `hitCount` are 0 and every chunk's list is empty, so the first request to any chunk is forwarded.
- R2: A request accepted with `reqValid` high yields `rspValid` high on the next cycle, with `rspChunk` and `rspObj` echoing the request. No request means no response.
- R3: A request whose object id is not a valid entry of its chunk's list is forwarded (`rspForward` = 1), and its id is inserted into that list.
- R4: A request whose object id matches a valid entry of its chunk's list is dropped (`rspForward` = 0) and `hitCount` grows by one on the same cycle the response appears.
- R5: Lists are private to each chunk, so an id stored for one chunk does not cause a drop in another chunk.
- R6: Inserts fill slots in round-robin order per chunk. After ENTRIES+1 distinct misses, the first id has been evicted and is forwarded again, while the others still hit.
- R7: A clear invalidates every entry of the named chunk in one cycle and restarts its round-robin slot at 0. Other chunks keep their entries.
- R8: When a clear and a request name the same chunk in the same cycle, the request is looked up against the emptied list and is forwarded. Its id then becomes that chunk's only entry.
- R9: `hitCount` stays unchanged on forwarded responses and idle cycles, and it wraps modulo 2^CNT_W.
- R10: Two back-to-back requests with the same chunk and object (and no clear) result in the second being dropped, because the first insert is visible to the next lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Lookup request strobe |
| reqChunk | input | CHUNK_W | Chunk id of the request |
| reqObj | input | OBJ_W | Object id of the request |
| clrValid | input | 1 | Clear strobe for one chunk's list |
| clrChunk | input | CHUNK_W | Chunk whose list is cleared |
| rspValid | output | 1 | Response strobe, one cycle after the request |
| rspForward | output | 1 | 1 = pass to intersection, 0 = dropped as repeat |
| rspChunk | output | CHUNK_W | Chunk id of the response |
| rspObj | output | OBJ_W | Object id of the response |
| hitCount | output | CNT_W | Running count of dropped requests |

## Verification
The hardest state to reach from the ports is a chunk's list that has just wrapped its round-robin slot. The same goes for the cycle where a clear and a lookup land on the same chunk. A directed sequence therefore issues five distinct ids to one chunk and then probes both the evicted id and a survivor. Another directed step drives a clear and a request together. The random phase then draws object ids from a range only twice the list depth, over eight chunks, with occasional clears. This keeps lists full, forces frequent evictions, and produces many back-to-back repeats. A reduced counter width lets the hit count wrap within the run.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  typedef struct packed {
    logic insert;
    logic clear;
  } mbox_strobe_t;

  typedef enum logic {
    RSP_DROP = 1'b0,
    RSP_FWD  = 1'b1
  } rsp_kind_e;
endpackage

// File: rtl/mbox_store.sv
module mbox_store
  import mbox_pkg::*;
#(
  parameter int NUM_CHUNKS = 8,
  parameter int ENTRIES    = 4,
  parameter int OBJ_W      = 16,
  parameter int CHUNK_W    = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  mbox_strobe_t       strb,
  input  logic [CHUNK_W-1:0] reqChunk,
  input  logic [OBJ_W-1:0]   reqObj,
  input  logic [CHUNK_W-1:0] clrChunk,
  output logic               rawHit
);
  localparam int ENT_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [NUM_CHUNKS-1:0] chunkMatch;

  for (genvar c = 0; c < NUM_CHUNKS; c++) begin : g_chunk
    logic [OBJ_W-1:0] tagArr [ENTRIES];
    logic [ENTRIES-1:0] vld;
    logic [ENTRIES-1:0] nextVld;
    logic [ENTRIES-1:0] baseVld;
    logic [ENTRIES-1:0] matchVec;
    logic [ENT_W-1:0] ptr;
    logic [ENT_W-1:0] basePtr;
    logic [ENT_W-1:0] nextPtr;
    logic clrHere;
    logic insHere;

    assign clrHere = strb.clear && (clrChunk == CHUNK_W'(c));
    assign insHere = strb.insert && (reqChunk == CHUNK_W'(c));
    assign basePtr = clrHere ? '0 : ptr;
    assign baseVld = clrHere ? '0 : vld;
    assign nextPtr = (basePtr == ENT_W'(ENTRIES - 1)) ? '0 : basePtr + 1'b1;

    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
      assign matchVec[e] = vld[e] && (tagArr[e] == reqObj);
      assign nextVld[e]  = baseVld[e] || (insHere && (basePtr == ENT_W'(e)));
    end

    assign chunkMatch[c] = |matchVec;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld <= '0;
        ptr <= '0;
        for (int e = 0; e < ENTRIES; e++) tagArr[e] <= '0;
      end else begin
        if (clrHere || insHere) begin
          vld <= nextVld;
          ptr <= insHere ? nextPtr : basePtr;
        end
        for (int e = 0; e < ENTRIES; e++) begin
          if (insHere && (basePtr == ENT_W'(e))) tagArr[e] <= reqObj;
        end
      end
    end
  end

  assign rawHit = chunkMatch[reqChunk];
endmodule

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
#(
  parameter int OBJ_W   = 16,
  parameter int CHUNK_W = 3,
  parameter int CNT_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reqValid,
  input  logic [CHUNK_W-1:0] reqChunk,
  input  logic [OBJ_W-1:0]   reqObj,
  input  logic               clrValid,
  input  logic [CHUNK_W-1:0] clrChunk,
  input  logic               rawHit,
  output mbox_strobe_t       strb,
  output logic               rspValid,
  output logic               rspForward,
  output logic [CHUNK_W-1:0] rspChunk,
  output logic [OBJ_W-1:0]   rspObj,
  output logic [CNT_W-1:0]   hitCount
);
  logic sameClr;
  logic hitNow;
  rsp_kind_e kind;

  assign sameClr     = clrValid && (clrChunk == reqChunk);
  assign hitNow      = rawHit && !sameClr;
  assign kind        = hitNow ? RSP_DROP : RSP_FWD;
  assign strb.clear  = clrValid;
  assign strb.insert = reqValid && !hitNow;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rspValid   <= 1'b0;
      rspForward <= 1'b0;
      rspChunk   <= '0;
      rspObj     <= '0;
      hitCount   <= '0;
    end else begin
      rspValid <= reqValid;
      if (reqValid) begin
        rspForward <= (kind == RSP_FWD);
        rspChunk   <= reqChunk;
        rspObj     <= reqObj;
        if (hitNow) hitCount <= hitCount + 1'b1;
      end
    end
  end
endmodule

// File: rtl/obj_mailbox.sv
module obj_mailbox
  import mbox_pkg::*;
#(
  parameter int NUM_CHUNKS = 8,
  parameter int ENTRIES    = 4,
  parameter int OBJ_W      = 16,
  parameter int CNT_W      = 16,
  localparam int CHUNK_W   = (NUM_CHUNKS > 1) ? $clog2(NUM_CHUNKS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reqValid,
  input  logic [CHUNK_W-1:0] reqChunk,
  input  logic [OBJ_W-1:0]   reqObj,
  input  logic               clrValid,
  input  logic [CHUNK_W-1:0] clrChunk,
  output logic               rspValid,
  output logic               rspForward,
  output logic [CHUNK_W-1:0] rspChunk,
  output logic [OBJ_W-1:0]   rspObj,
  output logic [CNT_W-1:0]   hitCount
);
  mbox_strobe_t strb;
  logic rawHit;

  mbox_ctrl #(.OBJ_W(OBJ_W), .CHUNK_W(CHUNK_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .reqValid(reqValid), .reqChunk(reqChunk), .reqObj(reqObj),
    .clrValid(clrValid), .clrChunk(clrChunk), .rawHit(rawHit),
    .strb(strb), .rspValid(rspValid), .rspForward(rspForward),
    .rspChunk(rspChunk), .rspObj(rspObj), .hitCount(hitCount)
  );

  mbox_store #(.NUM_CHUNKS(NUM_CHUNKS), .ENTRIES(ENTRIES), .OBJ_W(OBJ_W),
               .CHUNK_W(CHUNK_W)) u_store (
    .clk(clk), .rst_n(rst_n), .strb(strb),
    .reqChunk(reqChunk), .reqObj(reqObj), .clrChunk(clrChunk),
    .rawHit(rawHit)
  );
endmodule

// File: rtl/mbox_checker.sv
module mbox_checker #(
  parameter int OBJ_W   = 16,
  parameter int CHUNK_W = 3,
  parameter int CNT_W   = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               reqValid,
  input logic [CHUNK_W-1:0] reqChunk,
  input logic [OBJ_W-1:0]   reqObj,
  input logic               clrValid,
  input logic [CHUNK_W-1:0] clrChunk,
  input logic               rspValid,
  input logic               rspForward,
  input logic [CHUNK_W-1:0] rspChunk,
  input logic [OBJ_W-1:0]   rspObj,
  input logic [CNT_W-1:0]   hitCount
);
  logic armed;
  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b0;
    else armed <= 1'b1;
  end

  // R2
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid |=> rspValid);
  // R2
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reqValid |=> !rspValid);
  // R2
  rsp_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid |=> (rspObj == $past(reqObj) && rspChunk == $past(reqChunk)));
  // R4
  drop_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && rspValid && !rspForward) |-> hitCount == CNT_W'($past(hitCount) + 1'b1));
  // R9
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !(rspValid && !rspForward)) |-> $stable(hitCount));
  // R8
  clear_same_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && clrValid && reqChunk == clrChunk) |=> rspForward);
  // R10
  repeat_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && reqValid && $past(reqValid) && !clrValid &&
     reqChunk == $past(reqChunk) && reqObj == $past(reqObj)) |=> (rspValid && !rspForward));
endmodule

bind obj_mailbox mbox_checker #(.OBJ_W(OBJ_W), .CHUNK_W(CHUNK_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqChunk(reqChunk), .reqObj(reqObj),
  .clrValid(clrValid), .clrChunk(clrChunk), .rspValid(rspValid), .rspForward(rspForward),
  .rspChunk(rspChunk), .rspObj(rspObj), .hitCount(hitCount)
);

// File: tb/test_obj_mailbox.sv
module test_obj_mailbox;
  localparam int NCH = 8;
  localparam int NENT = 4;
  localparam int OW = 16;
  localparam int CW = 4;
  localparam int CHW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reqValid = 1'b0;
  logic [CHW-1:0] reqChunk = '0;
  logic [OW-1:0] reqObj = '0;
  logic clrValid = 1'b0;
  logic [CHW-1:0] clrChunk = '0;
  logic rspValid, rspForward;
  logic [CHW-1:0] rspChunk;
  logic [OW-1:0] rspObj;
  logic [CW-1:0] hitCount;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  obj_mailbox #(.NUM_CHUNKS(NCH), .ENTRIES(NENT), .OBJ_W(OW), .CNT_W(CW)) i_obj_mailbox (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqChunk(reqChunk), .reqObj(reqObj),
    .clrValid(clrValid), .clrChunk(clrChunk), .rspValid(rspValid), .rspForward(rspForward),
    .rspChunk(rspChunk), .rspObj(rspObj), .hitCount(hitCount)
  );

  // reference model of the lists
  int mTag [NCH][NENT];
  bit mVld [NCH][NENT];
  int mPtr [NCH];
  int mCnt = 0;

  bit expValid = 0;
  bit expFwd = 0;
  int expChunk = 0;
  int expObj = 0;
  string expTag = "R2";

  function automatic bit modelLookup(int ch, int obj);
    for (int e = 0; e < NENT; e++)
      if (mVld[ch][e] && mTag[ch][e] == obj) return 1'b1;
    return 1'b0;
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // one cycle: verify results of the previous cycle, then drive new stimulus
  task automatic step(bit rv, int ch, int obj, bit cv, int cch, string tag);
    bit hit;
    @(negedge clk);
    check(rspValid == expValid, "R2", "rspValid", rspValid, expValid);
    if (expValid) begin
      check(rspForward == expFwd, expTag, "rspForward", rspForward, expFwd);
      check(rspChunk == CHW'(expChunk), "R2", "rspChunk", rspChunk, expChunk);
      check(rspObj == OW'(expObj), "R2", "rspObj", rspObj, expObj);
    end
    check(hitCount == CW'(mCnt), "R9", "hitCount", hitCount, mCnt % (1 << CW));
    reqValid = rv; reqChunk = CHW'(ch); reqObj = OW'(obj);
    clrValid = cv; clrChunk = CHW'(cch);
    if (cv) begin
      for (int e = 0; e < NENT; e++) mVld[cch][e] = 1'b0;
      mPtr[cch] = 0;
    end
    hit = rv && modelLookup(ch, obj);
    if (rv && !hit) begin
      mTag[ch][mPtr[ch]] = obj;
      mVld[ch][mPtr[ch]] = 1'b1;
      mPtr[ch] = (mPtr[ch] + 1) % NENT;
    end
    if (hit) mCnt = mCnt + 1;
    expValid = rv; expFwd = !hit; expChunk = ch; expObj = obj; expTag = tag;
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20517));
    for (int c = 0; c < NCH; c++) begin
      mPtr[c] = 0;
      for (int e = 0; e < NENT; e++) begin mVld[c][e] = 0; mTag[c][e] = 0; end
    end
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check(rspValid == 1'b0, "R1", "rspValid after reset", rspValid, 0);
    check(hitCount == '0, "R1", "hitCount after reset", hitCount, 0);
    for (int c = 0; c < NCH; c++) step(1, c, 5, 0, 0, "R1");
    // R3 new id forwarded, R4 repeat dropped
    step(1, 2, 9, 0, 0, "R3");
    step(0, 0, 0, 0, 0, "R2");
    step(1, 2, 9, 0, 0, "R4");
    // R10 back-to-back identical
    step(1, 6, 33, 0, 0, "R3");
    step(1, 6, 33, 0, 0, "R10");
    // R5 other chunk independent
    step(1, 3, 9, 0, 0, "R5");
    // R6 round-robin eviction
    step(0, 0, 0, 1, 1, "R7");
    for (int k = 0; k < NENT + 1; k++) step(1, 1, 20 + k, 0, 0, "R6");
    step(1, 1, 21, 0, 0, "R6");
    step(1, 1, 20, 0, 0, "R6");
    step(1, 1, 21, 0, 0, "R6");
    // R7 clear one chunk, others intact
    step(0, 0, 0, 1, 1, "R7");
    step(1, 1, 22, 0, 0, "R7");
    step(1, 2, 9, 0, 0, "R7");
    // R8 clear and request same chunk same cycle
    step(1, 4, 5, 1, 4, "R8");
    step(1, 4, 5, 0, 0, "R8");
    // random phase
    for (int n = 0; n < 4000; n++) begin
      bit rv, cv;
      rv = ($urandom % 4) != 0;
      cv = ($urandom % 20) == 0;
      step(rv, $urandom % NCH, $urandom % (2 * NENT), cv, $urandom % NCH, "R4");
    end
    step(0, 0, 0, 0, 0, "R2");
    step(0, 0, 0, 0, 0, "R2");
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule